// File: doc/BRIEF.md
# Accumulator Readout Rounding Formatter

This block turns a 48-bit multiply-accumulate result into a 32-bit word that a register-file write port can take. On a read request, the block reads the accumulator value on its input and formats it in one of four ways. It can produce a fractional readout with round-half-even and optional clamping. It can pass through the raw low word. It can produce a signed integer clamped to 32 bits. It can produce an unsigned integer clamped to all-ones.

The fractional readout has two widths. The half-word format takes the 16 bits that sit 24 places up. It always rounds on the 24 bits below them. The word format shifts the value right by 8. It rounds on the dropped byte only when the round bit is set. A saturate bit chooses between clamping to the signed range of the chosen width and plain truncation.

The result is held in a register. A valid strobe follows each request by exactly one cycle. The accumulator state itself is kept and updated outside this block.

Top module: `acc_readout_fmt`

## Requirements
- R1: While `rstN` is low, and after its release until the first request, `rdValid` is 0 and `rdData` is all zeros.
- R2: `rdValid` is high in exactly the cycle after a cycle with `rdReq` high. `rdData` takes a new value only after a request and holds its value in every other cycle, whatever the other inputs do.
- R3: `rdKind` is decoded as follows: 2'b00 is fractional, 2'b01 is raw, 2'b10 is signed integer, 2'b11 is unsigned integer. The raw kind returns `accIn[31:0]` unchanged. For the raw kind, `ctlSu`, `ctlRound` and `ctlSat` have no effect.
- R4: The signed kind treats `accIn` as a two's-complement value. It returns the low 32 bits when the value lies in [-2^31, 2^31-1]. Otherwise it returns 0x80000000 for a negative value and 0x7FFFFFFF for a positive one.
- R5: The unsigned kind returns `accIn[31:0]` when `accIn[47:32]` is zero, and 0xFFFFFFFF otherwise.
- R6: The fractional kind with `ctlSu`=0, `ctlRound`=0 and `ctlSat`=0 returns the low 32 bits of `accIn` shifted arithmetically right by 8.
- R7: The fractional kind with `ctlSu`=0 and `ctlRound`=1 adds one to the shifted value in two cases: when `accIn[7:0]` is above 0x80, or when it equals 0x80 and the shifted value is odd.
- R8: The fractional kind with `ctlSu`=0 and `ctlSat`=1 clamps the shifted and rounded value to 0x7FFFFFFF or 0x80000000 when it does not fit in 32 signed bits. Without `ctlSat` it returns the low 32 bits.
- R9: The fractional kind with `ctlSu`=1 takes `accIn[39:24]`, with the sign taken from `accIn[47]`. It always rounds half to even on `accIn[23:0]`: it adds one above 0x800000, and adds the value's LSB at exactly 0x800000. `ctlRound` has no effect.
- R10: In the 16-bit fractional mode, `rdData[31:16]` is zero. With `ctlSat`=1, a rounded value outside [-32768, 32767] gives 0x7FFF, or 0x8000 when negative. Otherwise the low 16 bits are returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdReq | input | 1 | Read request; the output loads on this cycle's edge |
| rdKind | input | 2 | Readout kind (00 fractional, 01 raw, 10 signed, 11 unsigned) |
| accIn | input | 48 | Accumulator value to format |
| ctlSu | input | 1 | Selects 16-bit fractional format |
| ctlRound | input | 1 | Rounding enable for 32-bit fractional format |
| ctlSat | input | 1 | Saturate instead of truncate in fractional formats |
| rdData | output | 32 | Registered formatted result |
| rdValid | output | 1 | High for one cycle after each request |

## Verification
Some properties are checked on every cycle by the assertions:
- the one-cycle request-to-valid relation;
- that the output holds between requests;
- that at most one format path is strobed;
- that unsigned overflow always gives all-ones;
- that an in-range signed value passes through;
- that the 16-bit mode keeps the upper half clear.

Other behaviour can only be shown by the bench's directed scenarios, together with a behavioural model run over random operands. This covers:
- the half-to-even tie cases on even and odd values in both widths;
- a rounding carry that pushes a value out of range;
- the negative clamp values;
- the fact that the control bits have no effect on the raw kind.

// File: rtl/acc_readout_pkg.sv
package acc_readout_pkg;

  typedef enum logic [1:0] {
    KIND_FRAC     = 2'b00,
    KIND_RAW      = 2'b01,
    KIND_SIGNED   = 2'b10,
    KIND_UNSIGNED = 2'b11
  } rdKindE;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic selFrac16;
    logic selFrac32;
    logic selRaw;
    logic selSigned;
    logic selUnsigned;
    logic roundEn;
    logic satEn;
  } fmtStrobeT;

endpackage

// File: rtl/acc_readout_round.sv
module acc_readout_round #(
  parameter int BASE_W = 40,
  parameter int REM_W  = 8
) (
  input  logic [BASE_W-1:0] base,
  input  logic [REM_W-1:0]  rem,
  input  logic              en,
  output logic [BASE_W:0]   sum
);
  localparam logic [REM_W-1:0] HALF = {1'b1, {(REM_W-1){1'b0}}};

  logic bump;

  always_comb begin
    bump = en && ((rem > HALF) || ((rem == HALF) && base[0]));
    sum  = {base[BASE_W-1], base} + {{BASE_W{1'b0}}, bump};
  end
endmodule

// File: rtl/acc_readout_ctrl.sv
module acc_readout_ctrl
  import acc_readout_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rdReq,
  input  rdKindE    kind,
  input  logic      ctlSu,
  input  logic      ctlRound,
  input  logic      ctlSat,
  output fmtStrobeT strb,
  output logic      rdValid
);

  always_comb begin
    strb      = '0;
    strb.load = rdReq;
    unique case (kind)
      KIND_FRAC: begin
        strb.selFrac16 = ctlSu;
        strb.selFrac32 = !ctlSu;
        strb.roundEn   = ctlRound && !ctlSu;
        strb.satEn     = ctlSat;
      end
      KIND_RAW:      strb.selRaw      = 1'b1;
      KIND_SIGNED:   strb.selSigned   = 1'b1;
      KIND_UNSIGNED: strb.selUnsigned = 1'b1;
      default:       strb.selRaw      = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= rdReq;
  end

  // R2
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> rdValid);

  // R2
  valid_only_after_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> !rdValid);

  // R3
  one_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.selFrac16, strb.selFrac32, strb.selRaw, strb.selSigned, strb.selUnsigned}));

endmodule

// File: rtl/acc_readout_dpath.sv
module acc_readout_dpath
  import acc_readout_pkg::*;
#(
  parameter int ACC_W      = 48,
  parameter int OUT_W      = 32,
  parameter int HALF_W     = 16,
  parameter int FINE_SHIFT = 8,
  parameter int HALF_SHIFT = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  fmtStrobeT        strb,
  input  logic [ACC_W-1:0] accIn,
  output logic [OUT_W-1:0] dataQ
);
  localparam int FINE_BASE_W = ACC_W - FINE_SHIFT;
  localparam int HALF_BASE_W = ACC_W - HALF_SHIFT;
  localparam int PAD_W       = OUT_W - HALF_W;

  localparam logic [OUT_W-1:0]  WORD_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0]  WORD_MIN = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic [HALF_W-1:0] HALF_MAX = {1'b0, {(HALF_W-1){1'b1}}};
  localparam logic [HALF_W-1:0] HALF_MIN = {1'b1, {(HALF_W-1){1'b0}}};

  logic [FINE_BASE_W:0] fineSum;
  logic [HALF_BASE_W:0] halfSum;
  logic                 fineFits, halfFits, sFits, uFits;
  logic [OUT_W-1:0]     fineWord, signedWord, unsignedWord, nextData;
  logic [HALF_W-1:0]    halfWord;

  // 32-bit fractional path, optional rounding on dropped byte
  acc_readout_round #(.BASE_W(FINE_BASE_W), .REM_W(FINE_SHIFT)) fineRound (
    .base (accIn[ACC_W-1:FINE_SHIFT]),
    .rem  (accIn[FINE_SHIFT-1:0]),
    .en   (strb.roundEn),
    .sum  (fineSum)
  );

  // 16-bit fractional path, rounding always on
  acc_readout_round #(.BASE_W(HALF_BASE_W), .REM_W(HALF_SHIFT)) halfRound (
    .base (accIn[ACC_W-1:HALF_SHIFT]),
    .rem  (accIn[HALF_SHIFT-1:0]),
    .en   (1'b1),
    .sum  (halfSum)
  );

  always_comb begin
    fineFits = (&fineSum[FINE_BASE_W:OUT_W-1]) || !(|fineSum[FINE_BASE_W:OUT_W-1]);
    halfFits = (&halfSum[HALF_BASE_W:HALF_W-1]) || !(|halfSum[HALF_BASE_W:HALF_W-1]);
    sFits    = (&accIn[ACC_W-1:OUT_W-1]) || !(|accIn[ACC_W-1:OUT_W-1]);
    uFits    = !(|accIn[ACC_W-1:OUT_W]);

    if (strb.satEn && !fineFits) fineWord = fineSum[FINE_BASE_W] ? WORD_MIN : WORD_MAX;
    else                         fineWord = fineSum[OUT_W-1:0];

    if (strb.satEn && !halfFits) halfWord = halfSum[HALF_BASE_W] ? HALF_MIN : HALF_MAX;
    else                         halfWord = halfSum[HALF_W-1:0];

    if (sFits) signedWord = accIn[OUT_W-1:0];
    else       signedWord = accIn[ACC_W-1] ? WORD_MIN : WORD_MAX;

    unsignedWord = uFits ? accIn[OUT_W-1:0] : {OUT_W{1'b1}};

    nextData = accIn[OUT_W-1:0];
    if (strb.selFrac16)   nextData = {{PAD_W{1'b0}}, halfWord};
    if (strb.selFrac32)   nextData = fineWord;
    if (strb.selSigned)   nextData = signedWord;
    if (strb.selUnsigned) nextData = unsignedWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          dataQ <= '0;
    else if (strb.load) dataQ <= nextData;
  end

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(dataQ));

  // R5
  unsigned_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.selUnsigned && (accIn[ACC_W-1:OUT_W] != '0)) |=> (dataQ == {OUT_W{1'b1}}));

  // R4
  signed_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.selSigned && sFits) |=> (dataQ == $past(accIn[OUT_W-1:0])));

  // R10
  half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.selFrac16) |=> (dataQ[OUT_W-1:HALF_W] == '0));

endmodule

// File: rtl/acc_readout_fmt.sv
module acc_readout_fmt
  import acc_readout_pkg::*;
#(
  parameter int ACC_W      = 48,
  parameter int OUT_W      = 32,
  parameter int HALF_W     = 16,
  parameter int FINE_SHIFT = 8,
  parameter int HALF_SHIFT = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdReq,
  input  logic [1:0]       rdKind,
  input  logic [ACC_W-1:0] accIn,
  input  logic             ctlSu,
  input  logic             ctlRound,
  input  logic             ctlSat,
  output logic [OUT_W-1:0] rdData,
  output logic             rdValid
);
  fmtStrobeT strb;

  acc_readout_ctrl ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rdReq    (rdReq),
    .kind     (rdKindE'(rdKind)),
    .ctlSu    (ctlSu),
    .ctlRound (ctlRound),
    .ctlSat   (ctlSat),
    .strb     (strb),
    .rdValid  (rdValid)
  );

  acc_readout_dpath #(
    .ACC_W(ACC_W), .OUT_W(OUT_W), .HALF_W(HALF_W),
    .FINE_SHIFT(FINE_SHIFT), .HALF_SHIFT(HALF_SHIFT)
  ) dpath (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .accIn (accIn),
    .dataQ (rdData)
  );
endmodule

// File: tb/acc_readout_fmt_test.sv
module acc_readout_fmt_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdReq = 1'b0;
  logic [1:0]  rdKind = 2'b00;
  logic [47:0] accIn = '0;
  logic        ctlSu = 1'b0, ctlRound = 1'b0, ctlSat = 1'b0;
  logic [31:0] rdData;
  logic        rdValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] expData  = '0;
  logic        expValid = 1'b0;

  always #4 clk = ~clk;

  acc_readout_fmt uut (
    .clk(clk), .rstN(rstN), .rdReq(rdReq), .rdKind(rdKind), .accIn(accIn),
    .ctlSu(ctlSu), .ctlRound(ctlRound), .ctlSat(ctlSat),
    .rdData(rdData), .rdValid(rdValid)
  );

  // Behavioural reference
  function automatic logic [31:0] refModel(input logic [1:0] k, input logic [47:0] a,
                                           input bit su, input bit rnd, input bit sat);
    longint v, r;
    v = {{16{a[47]}}, a};
    case (k)
      2'b01: return a[31:0];
      2'b10: begin
        if (v >= -64'sd2147483648 && v <= 64'sd2147483647) return a[31:0];
        return (v < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
      end
      2'b11: return (a[47:32] == 16'h0) ? a[31:0] : 32'hFFFF_FFFF;
      default: begin
        if (su) begin
          r = v >>> 24;
          if ((v & 64'hFF_FFFF) > 64'h80_0000) r = r + 1;
          else if ((v & 64'hFF_FFFF) == 64'h80_0000) r = r + (r & 1);
          if (sat && (r > 32767 || r < -32768)) return (r < 0) ? 32'h8000 : 32'h7FFF;
          return {16'h0, r[15:0]};
        end
        r = v >>> 8;
        if (rnd) begin
          if ((v & 64'hFF) > 64'h80) r = r + 1;
          else if ((v & 64'hFF) == 64'h80) r = r + (r & 1);
        end
        if (sat && (r > 64'sd2147483647 || r < -64'sd2147483648))
          return (r < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
        return r[31:0];
      end
    endcase
  endfunction

  task automatic compare(input string tag);
    checks++;
    if (rdValid !== expValid) begin
      fails++;
      $display("FAIL %s valid actual=%0b expected=%0b", tag, rdValid, expValid);
    end
    checks++;
    if (rdData !== expData) begin
      fails++;
      $display("FAIL %s data actual=%h expected=%h", tag, rdData, expData);
    end
  endtask

  // Called at a negedge; applies inputs, checks one cycle later at next negedge
  task automatic step(input bit req, input logic [1:0] k, input logic [47:0] a,
                      input bit su, input bit rnd, input bit sat, input string tag);
    rdReq = req; rdKind = k; accIn = a; ctlSu = su; ctlRound = rnd; ctlSat = sat;
    expValid = req;
    if (req) expData = refModel(k, a, su, rnd, sat);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  function automatic string tagFor(input logic [1:0] k, input bit su, input bit rnd, input bit sat);
    if (k == 2'b01) return "R3";
    if (k == 2'b10) return "R4";
    if (k == 2'b11) return "R5";
    if (su) return sat ? "R10" : "R9";
    if (sat) return "R8";
    return rnd ? "R7" : "R6";
  endfunction

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rstN = 1'b1;
    step(0, 2'b01, 48'h1234_5678_9ABC, 1, 1, 1, "R1 after reset idle");

    // Raw, control bits ignored
    step(1, 2'b01, 48'hFEDC_8765_4321, 1, 1, 1, "R3 raw ctl set");
    step(1, 2'b01, 48'hFEDC_8765_4321, 0, 0, 0, "R3 raw ctl clear");
    // Hold with changing inputs
    step(0, 2'b11, 48'hFFFF_0000_0000, 0, 0, 0, "R2 hold");
    step(0, 2'b00, 48'h0000_0000_0000, 1, 1, 1, "R2 hold again");

    // Signed
    step(1, 2'b10, 48'h0000_7FFF_FFFF, 0, 0, 0, "R4 max fit");
    step(1, 2'b10, 48'h0000_8000_0000, 0, 0, 0, "R4 pos clamp");
    step(1, 2'b10, 48'hFFFF_8000_0000, 0, 0, 0, "R4 min fit");
    step(1, 2'b10, 48'hFFFF_7FFF_FFFF, 0, 0, 0, "R4 neg clamp");

    // Unsigned
    step(1, 2'b11, 48'h0000_FFFF_FFFF, 0, 0, 0, "R5 fit");
    step(1, 2'b11, 48'h0001_0000_0000, 0, 0, 0, "R5 clamp");

    // Fractional 32
    step(1, 2'b00, 48'h0012_3456_78FF, 0, 0, 0, "R6 plain shift");
    step(1, 2'b00, 48'hF012_3456_7801, 0, 0, 0, "R6 negative shift");
    step(1, 2'b00, 48'h0000_1234_5680, 0, 1, 0, "R7 tie even");
    step(1, 2'b00, 48'h0000_1234_5780, 0, 1, 0, "R7 tie odd");
    step(1, 2'b00, 48'h0000_1234_5681, 0, 1, 0, "R7 above half");
    step(1, 2'b00, 48'h0000_1234_567F, 0, 1, 0, "R7 below half");
    step(1, 2'b00, 48'h4000_0000_0000, 0, 0, 1, "R8 pos clamp");
    step(1, 2'b00, 48'h8000_0000_0000, 0, 0, 1, "R8 neg clamp");
    step(1, 2'b00, 48'h4000_0000_0000, 0, 0, 0, "R8 truncate");
    step(1, 2'b00, 48'h007F_FFFF_FFFF, 0, 1, 1, "R8 round carry clamp");
    step(1, 2'b00, 48'h007F_FFFF_FFFF, 0, 1, 0, "R8 round carry wrap");

    // Fractional 16
    step(1, 2'b00, 48'h0012_3480_0000, 1, 0, 0, "R9 tie even");
    step(1, 2'b00, 48'h0012_3580_0000, 1, 0, 0, "R9 tie odd");
    step(1, 2'b00, 48'h0012_347F_FFFF, 1, 1, 0, "R9 below half");
    step(1, 2'b00, 48'h0012_3480_0001, 1, 0, 0, "R9 above half");
    step(1, 2'b00, 48'h007F_FFFF_FFFF, 1, 0, 1, "R10 carry clamp");
    step(1, 2'b00, 48'hF000_0000_0000, 1, 0, 1, "R10 neg clamp");
    step(1, 2'b00, 48'hF000_0000_0000, 1, 0, 0, "R10 truncate");
    step(1, 2'b00, 48'hFFFF_FF00_0000, 1, 0, 1, "R10 neg fit");

    // Back-to-back and mixed random traffic
    for (int i = 0; i < 400; i++) begin
      logic [1:0]  k;
      logic [47:0] a;
      bit su, rnd, sat, rq;
      k   = 2'($urandom);
      a   = {16'($urandom), 32'($urandom)};
      if (($urandom & 3) == 0) a[47:24] = {24{a[47]}};
      su  = 1'($urandom); rnd = 1'($urandom); sat = 1'($urandom);
      rq  = (($urandom & 3) != 0);
      step(rq, k, a, su, rnd, sat, rq ? tagFor(k, su, rnd, sat) : "R2");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule